// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Slave

This block is a two-wire serial-bus (I2C, standard mode) slave that does nothing but accept configuration writes. It brings the clock and data lines into the system clock domain, finds start and stop conditions, and compares the first byte of each transfer with its own device address. When the address matches, it acknowledges every byte and drops the first two bytes after the address, which carry a command code with no meaning here. The bytes that follow are written, one after another, into a fixed bank of six 8-bit registers. The first data byte goes to register 0.

All register contents are presented in parallel on one flat output bus, so surrounding logic can read its settings with no bus access. Register 0 comes up as 8'h70 and the other five come up as all ones. The data line is driven only by pulling it low through an output-enable signal, which suits an open-drain pad.

Top module: `cfg_i2c_slave`

## Requirements
- R1: While reset is held and after it, `sda_oe` is 0. Register 0 holds 8'h70 (bits 6:4 set, bits 7 and 3:0 clear) and registers 1 to 5 hold 8'hFF.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in the middle of a transfer begins a new transfer, and the next byte is treated as an address.
- R3: An address byte equal to 8'hD2 (7-bit address 1101001 followed by a write bit of 0) is acknowledged by pulling SDA low during the ninth clock.
- R4: Any other address byte, including 8'hD3 (a read), gets no acknowledge. All following bytes are ignored and no register changes until the next start.
- R5: After a matching address, the next two bytes are acknowledged and thrown away.
- R6: The bytes after the two discarded bytes are acknowledged and stored in order into registers 0 to 5. Each byte is taken MSB first, with each bit sampled on an SCL rising edge.
- R7: Bytes after the sixth data byte are acknowledged, and no register is written.
- R8: A stop after fewer than six data bytes ends the transfer. Registers already written keep their new values, and the rest keep their old values.
- R9: `sda_oe` rises only at the SCL falling edge that ends the eighth bit of a byte and falls at the next SCL falling edge. It stays 0 for the whole of every data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_o | output | 48 | Register contents; register n at bits 8n+7:8n |

## Verification
Every bus event passes through the two synchronizer flops and one edge flop. As a result, `sda_oe` changes one system clock after the edge is detected, about four clocks after the SCL line moves. A register takes its new value one clock after that. The bench holds each SCL phase for ten clocks and samples the acknowledge in the middle of the ninth SCL high phase, well after the four-clock lag has passed. It checks register contents ten clocks after a stop, when no write can still be on its way.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_SKIP
  } eng_state_t;

  localparam int unsigned BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    return (idx == 0) ? 8'h70 : 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = scl_d & ~scl_lvl;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h69,
  parameter int unsigned SKIP_BYTES = 2,
  parameter int unsigned NUM_REGS   = 6,
  localparam int unsigned IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned LAST_POS  = 1 + SKIP_BYTES + NUM_REGS,
  localparam int unsigned CNT_W     = $clog2(LAST_POS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);

  eng_state_t        state;
  logic [3:0]        bit_cnt;
  logic [CNT_W-1:0]  byte_pos;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  data_pos;
  logic              pos_is_data;

  assign data_pos    = byte_pos - CNT_W'(SKIP_BYTES + 1);
  assign pos_is_data = (byte_pos > CNT_W'(SKIP_BYTES)) &&
                       (byte_pos <= CNT_W'(SKIP_BYTES + NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_pos <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        byte_pos <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (byte_pos == '0) begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                  state  <= ST_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
                if (pos_is_data) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= data_pos[IDX_W-1:0];
                  wr_data <= shreg;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              state    <= ST_RX;
              bit_cnt  <= '0;
              if (byte_pos != CNT_W'(LAST_POS))
                byte_pos <= byte_pos + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[g*BYTE_W +: BYTE_W] <= reg_default(g);
      else if (wr_en && wr_idx == IDX_W'(g))
        cfg_o[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SKIP_BYTES  = 2,
  parameter int unsigned NUM_REGS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rx_engine #(
    .DEV_ADDR   (DEV_ADDR),
    .SKIP_BYTES (SKIP_BYTES),
    .NUM_REGS   (NUM_REGS)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_o   (cfg_o)
  );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_i,
  input logic                       sda_oe,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  function automatic logic [NUM_REGS*BYTE_W-1:0] default_flat();
    logic [NUM_REGS*BYTE_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*BYTE_W +: BYTE_W] = reg_default(i);
    return v;
  endfunction

  // R1: reset leaves defaults and a released data line
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!sda_oe && cfg_o == default_flat()));

  // R9: acknowledge drive starts only while the clock line is low
  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R9: no change of the drive without a recent clock-line edge
  p_oe_needs_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (scl_i == $past(scl_i, 1) && scl_i == $past(scl_i, 2) &&
     scl_i == $past(scl_i, 3) && scl_i == $past(scl_i, 4) &&
     scl_i == $past(scl_i, 5)) |-> $stable(sda_oe));

  // R6: a register only changes while its byte is being acknowledged
  p_cfg_change_acked_r6: assert property (@(posedge clk) disable iff (rst)
    $changed(cfg_o) |-> sda_oe);

  // R9: drive output always known
  p_oe_known_r9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sda_oe));

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .cfg_o  (cfg_o)
);

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;

  localparam int NREG = 6;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_o;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] model [NREG];
  logic [7:0] tx [12];

  always #5 clk = ~clk;

  cfg_i2c_slave u0 (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .cfg_o  (cfg_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit oe_in_data);
    oe_in_data = 0;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      sda_m = b[i];
      hold(Q);
      scl_m = 1'b1;
      hold(Q);
      if (sda_oe) oe_in_data = 1;
      hold(Q);
      scl_m = 1'b0;
    end
    hold(Q);
    sda_m = 1'b1;
    hold(Q);
    scl_m = 1'b1;
    hold(Q);
    acked = (sda_line == 1'b0) && sda_oe;
    hold(Q);
    scl_m = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++)
      check($sformatf("%s reg%0d", tag, i), {24'h0, cfg_o[i*8 +: 8]}, {24'h0, model[i]});
  endtask

  // tx[0] address, tx[1..2] discarded, tx[3..] data; model follows R3..R8
  task automatic do_xfer(input int n_data, input bit with_stop, input string tag);
    bit ack, oe_bad, addr_ok;
    addr_ok = (tx[0] == 8'hD2);
    bus_start();
    for (int k = 0; k < 3 + n_data; k++) begin
      send_byte(tx[k], ack, oe_bad);
      check($sformatf("%s R9 no drive in data bits byte%0d", tag, k), {31'h0, oe_bad}, 32'h0);
      if (k == 0)
        check($sformatf("%s R3/R4 address ack", tag), {31'h0, ack}, {31'h0, addr_ok});
      else if (k < 3)
        check($sformatf("%s R5 discarded byte ack", tag), {31'h0, ack}, {31'h0, addr_ok});
      else if (k < 3 + NREG)
        check($sformatf("%s R6 data ack", tag), {31'h0, ack}, {31'h0, addr_ok});
      else
        check($sformatf("%s R7 extra byte ack", tag), {31'h0, ack}, {31'h0, addr_ok});
      if (addr_ok && k >= 3 && k < 3 + NREG) model[k-3] = tx[k];
    end
    if (with_stop) bus_stop();
    hold(10);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h70 : 8'hFF;
    hold(8);
    check("R1 oe during reset", {31'h0, sda_oe}, 32'h0);
    rst = 1'b0;
    hold(4);
    check("R1 oe after reset", {31'h0, sda_oe}, 32'h0);
    check_regs("R1 defaults");

    // full write; discarded bytes must not land anywhere (R5, R6)
    tx[0] = 8'hD2; tx[1] = 8'h55; tx[2] = 8'hAA;
    for (int i = 0; i < NREG; i++) tx[3+i] = 8'hA1 + 8'(i);
    do_xfer(6, 1, "full");
    check_regs("R6 full write");

    // early stop after two data bytes
    tx[3] = 8'h13; tx[4] = 8'h24;
    do_xfer(2, 1, "early");
    check_regs("R8 early stop");

    // wrong address
    tx[0] = 8'hD4;
    for (int i = 0; i < NREG; i++) tx[3+i] = 8'h0F;
    do_xfer(6, 1, "badaddr");
    check_regs("R4 wrong address");

    // read bit set
    tx[0] = 8'hD3;
    do_xfer(6, 1, "read");
    check_regs("R4 read ignored");

    // bytes beyond the last register
    tx[0] = 8'hD2;
    for (int i = 0; i < 9; i++) tx[3+i] = 8'h30 + 8'(i);
    do_xfer(9, 1, "extra");
    check_regs("R7 overflow");

    // repeated start restarts addressing
    tx[3] = 8'hC1; tx[4] = 8'hC2;
    do_xfer(2, 0, "rs_a");
    tx[3] = 8'hE7;
    do_xfer(1, 1, "rs_b");
    check_regs("R2 repeated start");

    // random transfers
    void'($urandom(32'd2024));
    for (int t = 0; t < 10; t++) begin
      int n;
      tx[0] = (($urandom % 4) != 0) ? 8'hD2 : 8'($urandom);
      for (int k = 1; k < 12; k++) tx[k] = 8'($urandom);
      n = $urandom % 9;
      do_xfer(n, 1, $sformatf("rand%0d", t));
      check_regs($sformatf("R6 random %0d", t));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule